// File: doc/BRIEF.md
# Receive Nibble-to-Byte Aligner

This block sits behind the clock-crossing stage of a receive path. It accepts a four-bit data stream in which each nibble is marked by a one-cycle strobe, under a data-valid level that spans the whole frame. Preamble nibbles are skipped until the start-of-frame delimiter appears. After that, nibbles are paired into bytes and one byte strobe is issued for every second accepted nibble. The chip clock may run faster than the nibble rate, so cycles without a strobe are simply waited out.

A small idle / low-nibble / high-nibble state machine is restarted by every frame. When data-valid falls, the state the machine is in shows whether the frame ended on a whole byte or on a stray trailing nibble. The end-of-frame report carries the number of complete bytes, a misalignment flag, and sticky flags for receive errors and collisions that were seen while data-valid was high. These flags let a later stage throw the frame away. CRC checking and address filtering happen further downstream.

Top module: `rx_nibble_aligner`

## Requirements
- R1: While reset is high, and in the cycle after it is released, byte_stb, sof_pulse and eof_pulse are 0, and byte_data, eof_len, eof_align_err, eof_rx_err and eof_col are all 0.
- R2: A nibble counts as accepted only when nib_valid and rx_dv are both 1. The delimiter is an accepted 0x5 directly followed by an accepted 0xD. sof_pulse is 1 for exactly the cycle after the edge that accepts the 0xD. Any other accepted nibble during the search keeps the block searching, and no byte is issued before the delimiter.
- R3: After the delimiter, accepted nibbles alternate between low and high. The low nibble goes to byte_data[3:0] and the high nibble to byte_data[7:4]. byte_stb is 1 for the single cycle after the edge that accepts a high nibble and 0 after a low nibble.
- R4: A nib_valid strobe while rx_dv is 0 is ignored. Cycles with rx_dv 1 and nib_valid 0 neither advance the search nor the byte pairing.
- R5: After a delimiter, the first edge that samples rx_dv at 0 ends the frame. eof_pulse is 1 for the next cycle, and eof_len then holds the number of complete bytes since the delimiter. The preamble and delimiter are not counted.
- R6: eof_align_err is 1 at end of frame exactly when an odd trailing nibble was received, and 0 otherwise.
- R7: The byte count saturates at 2047, so a longer frame reports eof_len = 2047.
- R8: eof_rx_err is 1 at end of frame exactly when rx_er was 1 in some cycle with rx_dv 1 during that frame. The flag starts clear for each new frame.
- R9: eof_col is 1 at end of frame exactly when rx_col was 1 in some cycle with rx_dv 1 during that frame. The flag starts clear for each new frame.
- R10: If rx_dv falls before a delimiter has been found, neither sof_pulse nor eof_pulse is produced.
- R11: A single cycle of rx_dv at 0 between two frames is enough. The next frame's preamble nibble, strobed in the very next cycle, is searched normally, and its report does not carry over flags from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data-valid level; its fall ends the frame |
| nib_valid | input | 1 | One-cycle strobe marking a new nibble |
| nib_data | input | 4 | Received nibble |
| rx_er | input | 1 | Receive error indication |
| rx_col | input | 1 | Collision indication |
| byte_data | output | 8 | Assembled byte, held until the next one |
| byte_stb | output | 1 | One-cycle strobe for a new byte |
| sof_pulse | output | 1 | One-cycle pulse after the delimiter |
| eof_pulse | output | 1 | One-cycle pulse at end of frame |
| eof_len | output | 11 | Complete bytes in the frame (saturating) |
| eof_align_err | output | 1 | Frame ended on an odd nibble |
| eof_rx_err | output | 1 | Receive error seen during the frame |
| eof_col | output | 1 | Collision seen during the frame |

## Verification
Two events can meet in one cycle. The end-of-frame report of one frame and the restart of the delimiter search for the next frame coincide when rx_dv is low for a single cycle and a preamble nibble is strobed in the very next cycle. The bench provokes this by running a frame that has a collision straight into a clean frame. It judges the result by checking that the first report flags the collision, and that the second frame still gets its delimiter pulse, all of its bytes and a report with both flags clear.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LO   = 2'd2,
    ST_HI   = 2'd3
  } rxa_state_e;
endpackage

// File: rtl/rxa_sfd_hunter.sv
module rxa_sfd_hunter #(
  parameter int                NIB_W      = 4,
  parameter logic [NIB_W-1:0]  SFD_FIRST  = 'h5,
  parameter logic [NIB_W-1:0]  SFD_SECOND = 'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             nib_ok,
  input  logic [NIB_W-1:0] nib,
  output logic             hit
);
  logic prev_first;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      prev_first <= 1'b0;
    end else if (nib_ok) begin
      prev_first <= (nib == SFD_FIRST);
    end
  end

  assign hit = active && nib_ok && prev_first && (nib == SFD_SECOND);
endmodule

// File: rtl/rxa_byte_packer.sv
module rxa_byte_packer #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_lo,
  input  logic              take_hi,
  input  logic [NIB_W-1:0]  nib,
  output logic [BYTE_W-1:0] byte_q,
  output logic              stb_q
);
  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      byte_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= take_hi;
      if (take_lo) begin
        lo_q <= nib;
      end
      if (take_hi) begin
        byte_q <= {nib, lo_q};
      end
    end
  end
endmodule

// File: rtl/rxa_len_counter.sv
module rxa_len_counter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] cnt
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_nibble_aligner.sv
module rx_nibble_aligner #(
  parameter int               NIB_W      = 4,
  parameter int               LEN_W      = 11,
  parameter logic [NIB_W-1:0] SFD_FIRST  = 'h5,
  parameter logic [NIB_W-1:0] SFD_SECOND = 'hD,
  localparam int              BYTE_W     = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic              nib_valid,
  input  logic [NIB_W-1:0]  nib_data,
  input  logic              rx_er,
  input  logic              rx_col,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_stb,
  output logic              sof_pulse,
  output logic              eof_pulse,
  output logic [LEN_W-1:0]  eof_len,
  output logic              eof_align_err,
  output logic              eof_rx_err,
  output logic              eof_col
);
  import rxa_pkg::*;

  rxa_state_e       state;
  logic             nib_ok;
  logic             searching;
  logic             sfd_hit;
  logic             take_lo;
  logic             take_hi;
  logic [LEN_W-1:0] byte_cnt;
  logic             err_acc;
  logic             col_acc;

  assign nib_ok    = rx_dv && nib_valid;
  assign searching = rx_dv && ((state == ST_IDLE) || (state == ST_HUNT));
  assign take_lo   = nib_ok && (state == ST_LO);
  assign take_hi   = nib_ok && (state == ST_HI);

  rxa_sfd_hunter #(
    .NIB_W      (NIB_W),
    .SFD_FIRST  (SFD_FIRST),
    .SFD_SECOND (SFD_SECOND)
  ) u_hunter (
    .clk    (clk),
    .rst    (rst),
    .active (searching),
    .nib_ok (nib_ok),
    .nib    (nib_data),
    .hit    (sfd_hit)
  );

  rxa_byte_packer #(
    .NIB_W (NIB_W)
  ) u_packer (
    .clk     (clk),
    .rst     (rst),
    .take_lo (take_lo),
    .take_hi (take_hi),
    .nib     (nib_data),
    .byte_q  (byte_data),
    .stb_q   (byte_stb)
  );

  rxa_len_counter #(
    .LEN_W (LEN_W)
  ) u_len (
    .clk (clk),
    .rst (rst),
    .clr (sfd_hit),
    .inc (take_hi),
    .cnt (byte_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      sof_pulse     <= 1'b0;
      eof_pulse     <= 1'b0;
      eof_len       <= '0;
      eof_align_err <= 1'b0;
      eof_rx_err    <= 1'b0;
      eof_col       <= 1'b0;
      err_acc       <= 1'b0;
      col_acc       <= 1'b0;
    end else begin
      sof_pulse <= sfd_hit;
      eof_pulse <= 1'b0;
      err_acc   <= rx_dv ? (err_acc || rx_er)  : 1'b0;
      col_acc   <= rx_dv ? (col_acc || rx_col) : 1'b0;
      case (state)
        ST_IDLE: begin
          if (rx_dv) begin
            state <= sfd_hit ? ST_LO : ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (!rx_dv) begin
            state <= ST_IDLE;
          end else if (sfd_hit) begin
            state <= ST_LO;
          end
        end
        ST_LO, ST_HI: begin
          if (!rx_dv) begin
            eof_pulse     <= 1'b1;
            eof_len       <= byte_cnt;
            eof_align_err <= (state == ST_HI);
            eof_rx_err    <= err_acc;
            eof_col       <= col_acc;
            state         <= ST_IDLE;
          end else if (nib_ok) begin
            state <= (state == ST_LO) ? ST_HI : ST_LO;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxa_aligner_checker.sv
module rxa_aligner_checker #(
  parameter int               NIB_W      = 4,
  parameter int               LEN_W      = 11,
  parameter logic [NIB_W-1:0] SFD_FIRST  = 'h5,
  parameter logic [NIB_W-1:0] SFD_SECOND = 'hD
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_dv,
  input logic                 nib_valid,
  input logic [NIB_W-1:0]     nib_data,
  input logic                 rx_er,
  input logic                 rx_col,
  input logic [2*NIB_W-1:0]   byte_data,
  input logic                 byte_stb,
  input logic                 sof_pulse,
  input logic                 eof_pulse,
  input logic [LEN_W-1:0]     eof_len,
  input logic                 eof_align_err,
  input logic                 eof_rx_err,
  input logic                 eof_col
);
  a_r2_sof_follows_second: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> $past(rx_dv && nib_valid && (nib_data == SFD_SECOND)));

  a_r2_sof_single: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> !sof_pulse);

  a_r3_byte_from_strobe: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> $past(rx_dv && nib_valid));

  a_r3_byte_every_other: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);

  a_r5_eof_after_fall: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> !$past(rx_dv));

  a_r5_eof_no_byte: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> !byte_stb);

  a_r10_no_sof_eof_together: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> !sof_pulse);
endmodule

bind rx_nibble_aligner rxa_aligner_checker #(
  .NIB_W      (NIB_W),
  .LEN_W      (LEN_W),
  .SFD_FIRST  (SFD_FIRST),
  .SFD_SECOND (SFD_SECOND)
) u_rxa_chk (.*);

// File: tb/test_rx_nibble_aligner.sv
module test_rx_nibble_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_dv = 1'b0;
  logic        nib_valid = 1'b0;
  logic [3:0]  nib_data = 4'h0;
  logic        rx_er = 1'b0;
  logic        rx_col = 1'b0;
  logic [7:0]  byte_data;
  logic        byte_stb;
  logic        sof_pulse;
  logic        eof_pulse;
  logic [10:0] eof_len;
  logic        eof_align_err;
  logic        eof_rx_err;
  logic        eof_col;

  int n_checks = 0;
  int n_fail = 0;
  int cap_cnt = 0;
  int sof_cnt = 0;
  logic [7:0] cap [0:4095];

  always #2.5 clk = ~clk;

  rx_nibble_aligner i_rx_nibble_aligner (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .nib_valid(nib_valid),
    .nib_data(nib_data), .rx_er(rx_er), .rx_col(rx_col),
    .byte_data(byte_data), .byte_stb(byte_stb), .sof_pulse(sof_pulse),
    .eof_pulse(eof_pulse), .eof_len(eof_len), .eof_align_err(eof_align_err),
    .eof_rx_err(eof_rx_err), .eof_col(eof_col)
  );

  always @(negedge clk) begin
    if (!rst && byte_stb) begin
      cap[cap_cnt & 4095] = byte_data;
      cap_cnt = cap_cnt + 1;
    end
    if (!rst && sof_pulse) sof_cnt = sof_cnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit dv, input bit nv, input logic [3:0] d,
                      input bit er, input bit col);
    rx_dv = dv; nib_valid = nv; nib_data = d; rx_er = er; rx_col = col;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic run_frame(input string tag, input int npre, input int nbytes,
                           input bit odd, input bit er, input bit col,
                           input bit gaps, input logic [7:0] seed);
    int base = cap_cnt;
    int s0 = sof_cnt;
    int exp_len = (nbytes > 2047) ? 2047 : nbytes;
    for (int i = 0; i < npre; i++) step(1, 1, 4'h5, 0, 0);
    step(1, 1, 4'hD, 0, 0);
    chk("R2", {tag, " sof after delimiter"}, int'(sof_pulse), 1);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = pat(seed, i);
      if (gaps) step(1, 0, 4'h0, 0, 0);
      step(1, 1, b[3:0], er && (i == 0), 0);
      if (i == 0) chk("R3", {tag, " no strobe after low nibble"}, int'(byte_stb), 0);
      if (gaps) step(1, 0, 4'h0, 0, 0);
      step(1, 1, b[7:4], 0, col && (i == 0));
      if (i == 0) begin
        chk("R3", {tag, " strobe after high nibble"}, int'(byte_stb), 1);
        chk("R3", {tag, " first byte value"}, int'(byte_data), int'(b));
      end
    end
    if (odd) step(1, 1, 4'hA, 0, 0);
    step(0, 0, 4'h0, 0, 0);
    chk("R5", {tag, " eof pulse"}, int'(eof_pulse), 1);
    chk("R5", {tag, " eof length"}, int'(eof_len), exp_len);
    chk("R6", {tag, " align flag"}, int'(eof_align_err), int'(odd));
    chk("R8", {tag, " rx error flag"}, int'(eof_rx_err), int'(er));
    chk("R9", {tag, " collision flag"}, int'(eof_col), int'(col));
    chk("R3", {tag, " byte strobes"}, cap_cnt - base, nbytes);
    chk("R2", {tag, " one sof"}, sof_cnt - s0, 1);
    for (int i = 0; i < nbytes && i < 8; i++)
      chk("R3", {tag, " byte order"}, int'(cap[(base + i) & 4095]), int'(pat(seed, i)));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "stb in reset", int'(byte_stb | sof_pulse | eof_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pulses after reset", int'(byte_stb | sof_pulse | eof_pulse), 0);
    chk("R1", "data/len after reset", int'(byte_data) + int'(eof_len), 0);
    chk("R1", "flags after reset", int'(eof_align_err | eof_rx_err | eof_col), 0);
  endtask

  task automatic t_ignored_strobes();
    int s0 = sof_cnt;
    int c0 = cap_cnt;
    step(0, 1, 4'h5, 0, 0);
    step(0, 1, 4'hD, 0, 0);
    step(0, 1, 4'h3, 0, 0);
    step(0, 0, 4'h0, 0, 0);
    chk("R4", "no sof from strobes without dv", sof_cnt - s0, 0);
    chk("R4", "no bytes without dv", cap_cnt - c0, 0);
    chk("R10", "no eof without frame", int'(eof_pulse), 0);
  endtask

  task automatic t_noise_then_drop();
    int s0 = sof_cnt;
    step(1, 1, 4'h3, 0, 0);
    step(1, 1, 4'hD, 0, 0);
    step(1, 1, 4'h5, 0, 0);
    step(1, 0, 4'h0, 0, 0);
    step(1, 1, 4'hA, 0, 0);
    step(1, 1, 4'hD, 0, 0);
    step(0, 0, 4'h0, 0, 0);
    chk("R10", "no eof when delimiter missing", int'(eof_pulse), 0);
    chk("R10", "no sof when delimiter missing", sof_cnt - s0, 0);
    step(0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_noise_then_sync();
    step(1, 1, 4'h5, 0, 0);
    step(1, 1, 4'h3, 0, 0);
    step(1, 1, 4'hD, 0, 0);
    chk("R2", "broken pair gives no sof", int'(sof_pulse), 0);
    step(1, 1, 4'h5, 0, 0);
    step(1, 0, 4'h0, 0, 0);
    step(1, 1, 4'hD, 0, 0);
    chk("R2", "sof after gap inside delimiter", int'(sof_pulse), 1);
    step(0, 0, 4'h0, 0, 0);
    chk("R5", "empty frame eof", int'(eof_pulse), 1);
    chk("R5", "empty frame length", int'(eof_len), 0);
    step(0, 0, 4'h0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    step(0, 0, 4'h0, 0, 0);
    t_ignored_strobes();
    run_frame("basic", 7, 8, 0, 0, 0, 0, 8'h3C);
    step(0, 0, 4'h0, 0, 0);
    run_frame("dribble", 3, 4, 1, 0, 0, 0, 8'hA1);
    step(0, 0, 4'h0, 0, 0);
    run_frame("gapped_err", 5, 6, 0, 1, 0, 1, 8'h07);
    step(0, 0, 4'h0, 0, 0);
    run_frame("collision", 2, 3, 0, 0, 1, 0, 8'h90);
    run_frame("r11_back_to_back", 4, 5, 0, 0, 0, 0, 8'h55);
    step(0, 0, 4'h0, 0, 0);
    t_noise_then_drop();
    t_noise_then_sync();
    run_frame("r7_saturate", 1, 2050, 1, 0, 0, 0, 8'hE2);
    step(0, 0, 4'h0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule